// File: doc/BRIEF.md
# Word-Parallel CRC-5 Update Engine

This block keeps a 5-bit cyclic redundancy check state and advances it by a whole 4-bit data word in one clock. The generator polynomial is x^5 + x^2 + 1, whose low-order taps are 0x05. Each accepted word gives the same result as four steps of a one-bit Galois shift register. The next state comes from a fixed XOR network over the current state and the word.

That network is built at elaboration from one-hot responses. The module runs the serial step four times once for every single data bit with the state at zero, and once for every single state bit with the data at zero. By linearity, each output bit is then the XOR of the inputs whose one-hot response sets that bit.

A stream is started with an init strobe, which loads the all-ones seed. Words are then presented with a valid flag, and the running check value is read from the output at any time. Bit reflection, final inversion and framing belong to the surrounding logic.

Top module: `crc5_word_engine`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state becomes 5'b11111, and `crc_out` shows it after that edge.
- R2: With `crc_init` high and `din_valid` low, the state becomes 5'b11111 at the next edge.
- R3: With `din_valid` high and `crc_init` low, the state becomes four serial steps applied to the current state. The data bits go in from `din[3]` down to `din[0]`. One serial step with bit b computes fb = s[4]^b, shifts s left by one with a zero into bit 0, and then XORs fb into bits 0 and 2.
- R4: The word update equals, with c the current state and d = `din`: bit4 = c0^c3^d2; bit3 = c2^c4^d1^d3; bit2 = c1^c3^c4^d0^d2^d3; bit1 = c2^d1; bit0 = c1^c4^d0^d3.
- R5: With both `crc_init` and `din_valid` low, `crc_out` keeps its value.
- R6: With `crc_init` and `din_valid` both high, the word update of R3 is applied to 5'b11111, not to the old state.
- R7: A zero state updated with a zero word stays zero, and a nonzero state updated with a zero word stays nonzero.
- R8: From a zero state, a one-hot word with `din[0]`, `din[1]`, `din[2]` or `din[3]` set gives 5'h05, 5'h0A, 5'h14 or 5'h0D.
- R9: With a zero word, a one-hot state with bit 0, 1, 2, 3 or 4 set goes to 5'h10, 5'h05, 5'h0A, 5'h14 or 5'h0D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, loads the all-ones seed |
| crc_init | input | 1 | Starts a new stream by loading the seed; wins over the old state |
| din_valid | input | 1 | The word on `din` is accepted this cycle |
| din | input | 4 | Data word; bit 3 enters the serial equivalent first |
| crc_out | output | 5 | Current check state |

## Verification
A wrong coefficient in the XOR network shows up at `crc_out` one clock after the first accepted word that touches that coefficient. After that, the state keeps diverging, because the transition is invertible. The one-hot state and data checks isolate each column of the network. The bench reaches every one-hot state through two chosen words, so a single flipped coefficient appears within three beats. A broken hold or seed priority shows in the cycle after the idle or combined strobe.

// File: rtl/crc5_pkg.sv
package crc5_pkg;

  localparam int unsigned DEF_DATA_W = 4;
  localparam int unsigned DEF_CRC_W  = 5;
  localparam logic [DEF_CRC_W-1:0] DEF_POLY = 5'h05;

  // Cause of the state change in one cycle.
  typedef enum logic [1:0] {
    UPD_HOLD         = 2'd0,
    UPD_SEED         = 2'd1,
    UPD_ADVANCE      = 2'd2,
    UPD_SEED_ADVANCE = 2'd3
  } upd_kind_e;

endpackage

// File: rtl/crc_tap_matrix.sv
module crc_tap_matrix #(
  parameter int unsigned DATA_W = 4,
  parameter int unsigned CRC_W  = 5,
  parameter logic [CRC_W-1:0] POLY = 5'h05
) (
  input  logic [CRC_W-1:0]  cur_state,
  input  logic [DATA_W-1:0] word,
  output logic [CRC_W-1:0]  next_state
);

  typedef logic [CRC_W-1:0] crc_vec_t;
  typedef logic [DATA_W-1:0] dat_vec_t;

  // One serial Galois step per data bit, MSB of the word first.
  function automatic crc_vec_t serial_word(input crc_vec_t s, input dat_vec_t d);
    crc_vec_t r;
    logic     fb;
    r = s;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb = r[CRC_W-1] ^ d[i];
      r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    return r;
  endfunction

  // Row i holds which state bits feed output bit i.
  function automatic logic [CRC_W-1:0][CRC_W-1:0] build_state_rows();
    logic [CRC_W-1:0][CRC_W-1:0] m;
    crc_vec_t col;
    m = '0;
    for (int k = 0; k < CRC_W; k++) begin
      col = serial_word(crc_vec_t'(1) << k, '0);
      for (int i = 0; i < CRC_W; i++) m[i][k] = col[i];
    end
    return m;
  endfunction

  // Row i holds which data bits feed output bit i.
  function automatic logic [CRC_W-1:0][DATA_W-1:0] build_data_rows();
    logic [CRC_W-1:0][DATA_W-1:0] m;
    crc_vec_t col;
    m = '0;
    for (int j = 0; j < DATA_W; j++) begin
      col = serial_word('0, dat_vec_t'(1) << j);
      for (int i = 0; i < CRC_W; i++) m[i][j] = col[i];
    end
    return m;
  endfunction

  localparam logic [CRC_W-1:0][CRC_W-1:0]  STATE_ROWS = build_state_rows();
  localparam logic [CRC_W-1:0][DATA_W-1:0] DATA_ROWS  = build_data_rows();

  logic [CRC_W-1:0] state_part;
  logic [CRC_W-1:0] data_part;

  for (genvar gi = 0; gi < CRC_W; gi++) begin : g_out_bit
    assign state_part[gi] = ^(cur_state & STATE_ROWS[gi]);
    assign data_part[gi]  = ^(word & DATA_ROWS[gi]);
    assign next_state[gi] = state_part[gi] ^ data_part[gi];
  end

  // R3: the XOR network must equal the unrolled serial register.
  always_comb begin
    if (!$isunknown({cur_state, word})) begin
      a_r3_serial_equiv: assert (next_state == serial_word(cur_state, word))
        else $error("R3 XOR network differs from serial steps");
    end
  end

endmodule

// File: rtl/crc_seed_sel.sv
module crc_seed_sel
  import crc5_pkg::*;
#(
  parameter int unsigned CRC_W = 5
) (
  input  logic             init_req,
  input  logic             word_valid,
  input  logic [CRC_W-1:0] state_q,
  output logic [CRC_W-1:0] base_state,
  output upd_kind_e        kind
);

  localparam logic [CRC_W-1:0] SEED = '1;

  always_comb begin
    unique case ({init_req, word_valid})
      2'b00:   kind = UPD_HOLD;
      2'b10:   kind = UPD_SEED;
      2'b01:   kind = UPD_ADVANCE;
      default: kind = UPD_SEED_ADVANCE;
    endcase
  end

  assign base_state = init_req ? SEED : state_q;

endmodule

// File: rtl/crc_state_reg.sv
module crc_state_reg #(
  parameter int unsigned CRC_W = 5,
  parameter logic [CRC_W-1:0] SEED = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic [CRC_W-1:0] load_val,
  output logic [CRC_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)          q <= SEED;
    else if (load_en) q <= load_val;
  end

  // R1: the cycle after reset shows the seed.
  a_r1_reset_seed: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> q == SEED)
    else $error("R1 state not seeded after reset");

endmodule

// File: rtl/crc5_word_engine.sv
module crc5_word_engine
  import crc5_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned CRC_W  = DEF_CRC_W,
  parameter logic [CRC_W-1:0] POLY = DEF_POLY
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              crc_init,
  input  logic              din_valid,
  input  logic [DATA_W-1:0] din,
  output logic [CRC_W-1:0]  crc_out
);

  localparam logic [CRC_W-1:0] SEED = '1;

  logic [CRC_W-1:0] state_q;
  logic [CRC_W-1:0] base_state;
  logic [CRC_W-1:0] advanced;
  logic [CRC_W-1:0] load_val;
  logic             load_en;
  upd_kind_e        kind;

  crc_seed_sel #(.CRC_W(CRC_W)) u_sel (
    .init_req   (crc_init),
    .word_valid (din_valid),
    .state_q    (state_q),
    .base_state (base_state),
    .kind       (kind)
  );

  crc_tap_matrix #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(POLY)) u_mat (
    .cur_state  (base_state),
    .word       (din),
    .next_state (advanced)
  );

  // Named events for the checks below.
  logic ev_hold;
  logic ev_seed_only;
  logic ev_word;
  assign ev_hold      = (kind == UPD_HOLD);
  assign ev_seed_only = (kind == UPD_SEED);
  assign ev_word      = (kind == UPD_ADVANCE) || (kind == UPD_SEED_ADVANCE);

  assign load_en  = !ev_hold;
  assign load_val = ev_word ? advanced : SEED;

  crc_state_reg #(.CRC_W(CRC_W), .SEED(SEED)) u_reg (
    .clk      (clk),
    .rst      (rst),
    .load_en  (load_en),
    .load_val (load_val),
    .q        (state_q)
  );

  assign crc_out = state_q;

  a_r5_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!crc_init && !din_valid) |=> $stable(crc_out))
    else $error("R5 state moved while idle");

  a_r2_init_seed: assert property (@(posedge clk) disable iff (rst)
    (crc_init && !din_valid) |=> crc_out == SEED)
    else $error("R2 init did not load seed");

  a_r7_zero_fixed: assert property (@(posedge clk) disable iff (rst)
    (din_valid && !crc_init && crc_out == '0 && din == '0) |=> crc_out == '0)
    else $error("R7 zero state left zero");

  a_r7_nonzero_kept: assert property (@(posedge clk) disable iff (rst)
    (din_valid && !crc_init && crc_out != '0 && din == '0) |=> crc_out != '0)
    else $error("R7 nonzero state collapsed");

  a_r6_seed_word_moves: assert property (@(posedge clk) disable iff (rst)
    (crc_init && din_valid && din == '0) |=> crc_out != SEED)
    else $error("R6 seed not advanced by word");

endmodule

// File: tb/sim_crc5_word_engine.sv
module sim_crc5_word_engine;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       crc_init = 1'b0;
  logic       din_valid = 1'b0;
  logic [3:0] din = '0;
  logic [4:0] crc_out;

  int checks = 0;
  int failures = 0;
  logic [4:0] model = 5'h1f;
  logic [4:0] exp_q[$];
  string      tag_q[$];
  bit         done = 0;

  crc5_word_engine u0 (
    .clk(clk), .rst(rst), .crc_init(crc_init),
    .din_valid(din_valid), .din(din), .crc_out(crc_out)
  );

  always #(CLK_P/2) clk = ~clk;

  // Reference: bit-by-bit register, din[3] shifted in first.
  function automatic logic [4:0] ref_word(input logic [4:0] s, input logic [3:0] d);
    logic [4:0] r = s;
    for (int b = 3; b >= 0; b--) begin
      logic fb;
      fb = r[4] ^ d[b];
      r = {r[3:0], 1'b0} ^ {2'b00, fb, 1'b0, fb};
    end
    return r;
  endfunction

  // Driver: one cycle of stimulus; expected value queued for the monitor.
  task automatic beat(input bit r, input bit i, input bit v, input logic [3:0] d,
                      input string tag, input bit use_k = 0, input logic [4:0] k = '0);
    @(negedge clk);
    rst = r; crc_init = i; din_valid = v; din = d;
    if (r)      model = 5'h1f;
    else if (v) model = ref_word(i ? 5'h1f : model, d);
    else if (i) model = 5'h1f;
    exp_q.push_back(use_k ? k : model);
    tag_q.push_back(tag);
  endtask

  // Monitor: compares one queued item after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (exp_q.size() > 0) begin
        logic [4:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (crc_out !== e) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", t, crc_out, e);
        end
      end
    end
  end

  // Drives two words chosen so the state lands on target.
  task automatic reach(input logic [4:0] target, input string tag);
    bit found = 0;
    logic [3:0] fa = '0, fb = '0;
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        if (!found && ref_word(ref_word(model, 4'(a)), 4'(b)) == target) begin
          found = 1; fa = 4'(a); fb = 4'(b);
        end
    if (!found) begin
      checks++; failures++;
      $display("FAIL %s actual=unreachable expected=%h", tag, target);
    end
    beat(0, 0, 1, fa, tag);
    beat(0, 0, 1, fb, tag);
  endtask

  initial begin
    logic [4:0] dcol[4] = '{5'h05, 5'h0A, 5'h14, 5'h0D};
    logic [4:0] scol[5] = '{5'h10, 5'h05, 5'h0A, 5'h14, 5'h0D};
    beat(1, 0, 0, 4'h0, "R1 reset");
    beat(1, 0, 0, 4'h0, "R1 reset");
    // R4 spot values from the seed
    beat(0, 0, 1, 4'h0, "R4 seed+0", 1, 5'h06);
    beat(0, 1, 0, 4'h0, "R2 init");
    beat(0, 0, 1, 4'hF, "R4 seed+F", 1, 5'h10);
    beat(0, 0, 0, 4'h7, "R5 idle hold", 1, 5'h10);
    beat(0, 0, 0, 4'h3, "R5 idle hold");
    beat(0, 1, 1, 4'h0, "R6 init+valid", 1, 5'h06);
    beat(0, 1, 1, 4'h9, "R6 init+valid");
    // R8 data columns from zero state
    for (int j = 0; j < 4; j++) begin
      reach(5'h00, "R7 reach zero");
      beat(0, 0, 1, 4'(1 << j), "R8 data column", 1, dcol[j]);
    end
    reach(5'h00, "R7 reach zero");
    beat(0, 0, 1, 4'h0, "R7 zero stays", 1, 5'h00);
    // R9 state columns with zero data
    for (int k = 0; k < 5; k++) begin
      reach(5'(1 << k), "R9 reach one-hot");
      beat(0, 0, 1, 4'h0, "R9 state column", 1, scol[k]);
    end
    // R3 random streams with idles and restarts
    for (int n = 0; n < 400; n++) begin
      int sel = $urandom_range(0, 9);
      beat(0, sel == 0, sel != 1, 4'($urandom), "R3 stream");
    end
    beat(0, 0, 1, 4'h0, "R7 nonzero stays");
    beat(1, 0, 1, 4'h5, "R1 reset over valid");
    beat(0, 0, 0, 4'h0, "R5 idle after reset");
    @(negedge clk);
    @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(CLK_P * 100000);
        checks++; failures++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule